// File: doc/BRIEF.md
# Interlaced Composite Sync Sequencer

This block generates a simplified composite sync waveform for a 625-line interlaced picture at 25 frames per second. It runs from one clock whose frequency in MHz is the parameter `CLK_MHZ`, and it derives every pulse width and gap from that value. All durations are rounded down to whole clock cycles.

The waveform follows a fixed table of 622 entries per frame. Each entry is one sync (low) interval followed by one idle (high) interval. Vertical sync is a single long low pulse with no equalising or serration pulses. The high gaps next to the two vertical syncs are unequal, so the second field falls half a line after the first. The block also drives a one-cycle pulse at the start of each frame and a level that tells which field is being sent.

Top module: `pal_csync_seq`

## Requirements
In these requirements M is `CLK_MHZ` and HS is floor(47·M/10) cycles (4.7 µs). An entry's low interval comes first and its high interval follows.
- R1: While `rst` is 1, `csync_n` is 1 and `frame_start` is 0.
- R2: In the first cycle after `rst` returns to 0, entry 0 begins: `csync_n` is 0 and `frame_start` is 1.
- R3: Every entry other than 0, 310, 311 and 621 is HS cycles low and then 64·M−HS cycles high.
- R4: Entry 0 is 160·M cycles low and then 17·M cycles high.
- R5: Entry 310 is HS cycles low, and its high interval makes the whole entry 47·M cycles.
- R6: Entry 311 is 160·M cycles low and then 49·M cycles high.
- R7: Entry 621 is HS cycles low, and its high interval makes the whole entry 15·M cycles. Entry 0 follows it.
- R8: `frame_start` is 1 for exactly one cycle per frame, the first cycle of entry 0, and is 0 at every other time.
- R9: `field` is 0 during entries 0 to 310 and 1 during entries 311 to 621. It changes only on a falling edge of `csync_n`.
- R10: The time from one `frame_start` pulse to the next is 625·64·M cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at `CLK_MHZ` MHz |
| rst | input | 1 | Synchronous reset, active high |
| csync_n | output | 1 | Composite sync, low while a sync pulse is sent |
| frame_start | output | 1 | One-cycle pulse at the first cycle of entry 0 |
| field | output | 1 | Current field: 0 first, 1 second |

## Verification
The assertions check several properties on every cycle. The output stays idle during reset. The frame-start pulse lasts one cycle, falls inside a low interval, and coincides with field 0. The field flag moves only on a falling sync edge. No low pulse runs longer than a vertical sync. Frame starts are exactly one frame apart. The exact low and high length of each of the 622 entries, and the order of the special entries around the wrap, can only be shown by the bench. The bench follows two whole frames entry by entry. It also checks that a reset arriving in the middle of an entry restarts the table cleanly at entry 0.

// File: rtl/pal_csync_seq.sv
module pal_csync_seq #(
  parameter int CLK_MHZ = 50
) (
  input  logic clk,
  input  logic rst,
  output logic csync_n,
  output logic frame_start,
  output logic field
);
  localparam int ENTRIES  = 622;
  localparam int MID      = 311;
  localparam int IW       = $clog2(ENTRIES);
  localparam int LINE_CYC = 64 * CLK_MHZ;
  localparam int HS_CYC   = (47 * CLK_MHZ) / 10;
  localparam int VS_CYC   = 160 * CLK_MHZ;
  localparam int CW       = $clog2(VS_CYC);

  localparam logic [CW-1:0] HS_M1   = CW'(HS_CYC - 1);
  localparam logic [CW-1:0] VS_M1   = CW'(VS_CYC - 1);
  localparam logic [CW-1:0] STD_M1  = CW'(LINE_CYC - HS_CYC - 1);
  localparam logic [CW-1:0] TOP1_M1 = CW'(17 * CLK_MHZ - 1);
  localparam logic [CW-1:0] PRE2_M1 = CW'(47 * CLK_MHZ - HS_CYC - 1);
  localparam logic [CW-1:0] TOP2_M1 = CW'(49 * CLK_MHZ - 1);
  localparam logic [CW-1:0] PRE1_M1 = CW'(15 * CLK_MHZ - HS_CYC - 1);

  localparam logic [IW-1:0] I_FIRST = '0;
  localparam logic [IW-1:0] I_PRE2  = IW'(MID - 1);
  localparam logic [IW-1:0] I_TOP2  = IW'(MID);
  localparam logic [IW-1:0] I_LAST  = IW'(ENTRIES - 1);

  logic [IW-1:0] idx;
  logic          hi;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len_m1;

  always_comb begin
    if (!hi)
      len_m1 = (idx == I_FIRST || idx == I_TOP2) ? VS_M1 : HS_M1;
    else if (idx == I_FIRST)
      len_m1 = TOP1_M1;
    else if (idx == I_PRE2)
      len_m1 = PRE2_M1;
    else if (idx == I_TOP2)
      len_m1 = TOP2_M1;
    else if (idx == I_LAST)
      len_m1 = PRE1_M1;
    else
      len_m1 = STD_M1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= I_FIRST;
      hi  <= 1'b0;
      cnt <= '0;
    end else if (cnt == len_m1) begin
      cnt <= '0;
      hi  <= ~hi;
      if (hi) idx <= (idx == I_LAST) ? I_FIRST : idx + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign csync_n     = rst | hi;
  assign frame_start = !rst && idx == I_FIRST && !hi && cnt == '0;
  assign field       = idx >= I_TOP2;
endmodule

// File: rtl/pal_csync_chk.sv
module pal_csync_chk #(
  parameter int CLK_MHZ = 50
) (
  input logic clk,
  input logic rst,
  input logic csync_n,
  input logic frame_start,
  input logic field
);
  localparam int VS_CYC    = 160 * CLK_MHZ;
  localparam int FRAME_CYC = 625 * 64 * CLK_MHZ;

  int   lcnt;
  int   fcnt;
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      lcnt <= 0;
      fcnt <= 0;
      seen <= 1'b0;
    end else begin
      lcnt <= csync_n ? 0 : lcnt + 1;
      if (frame_start) begin
        fcnt <= 1;
        seen <= 1'b1;
      end else begin
        fcnt <= fcnt + 1;
      end
    end
  end

  AST_RST_IDLE: assert property (@(posedge clk) rst |-> (csync_n && !frame_start)); // R1
  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (rst) frame_start |=> !frame_start); // R8
  AST_FS_IN_SYNC: assert property (@(posedge clk) disable iff (rst) frame_start |-> !csync_n); // R8
  AST_FS_FIELD0: assert property (@(posedge clk) disable iff (rst) frame_start |-> !field); // R9
  AST_FIELD_EDGE: assert property (@(posedge clk) disable iff (rst) !$stable(field) |-> $fell(csync_n)); // R9
  AST_LOW_MAX: assert property (@(posedge clk) disable iff (rst) !csync_n |-> lcnt < VS_CYC); // R4
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst) (frame_start && seen) |-> fcnt == FRAME_CYC); // R10
endmodule

bind pal_csync_seq pal_csync_chk #(.CLK_MHZ(CLK_MHZ)) u_chk (
  .clk(clk), .rst(rst), .csync_n(csync_n), .frame_start(frame_start), .field(field)
);

// File: tb/pal_csync_seq_test.sv
module pal_csync_seq_test;
  localparam int M      = 1;
  localparam int HS     = (47 * M) / 10;
  localparam int VS     = 160 * M;
  localparam int LINE   = 64 * M;
  localparam int FRAME  = 625 * LINE;

  typedef struct {
    int idx;
    int low;
    int high;
    bit fld;
    bit fs;
  } entry_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csync_n, frame_start, field;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  entry_t q[$];

  pal_csync_seq #(.CLK_MHZ(M)) uut (
    .clk(clk), .rst(rst), .csync_n(csync_n), .frame_start(frame_start), .field(field)
  );

  always #10 clk = ~clk;

  function automatic entry_t model(input int i);
    entry_t e;
    e.idx  = i;
    e.fld  = (i >= 311);
    e.fs   = (i == 0);
    e.low  = (i == 0 || i == 311) ? VS : HS;
    case (i)
      0:       e.high = 17 * M;
      310:     e.high = 47 * M - HS;
      311:     e.high = 49 * M;
      621:     e.high = 15 * M - HS;
      default: e.high = LINE - HS;
    endcase
    return e;
  endfunction

  function automatic string tag(input int i);
    case (i)
      0:       return "R4";
      310:     return "R5";
      311:     return "R6";
      621:     return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: pushes expected entries starting at first, returns cycle total
  task automatic push_entries(input int first, input int n, output int cycles);
    cycles = 0;
    for (int k = 0; k < n; k++) begin
      entry_t e;
      e = model((first + k) % 622);
      q.push_back(e);
      cycles += e.low + e.high;
    end
  endtask

  // monitor
  entry_t cur;
  bit cur_v = 0;
  bit prev  = 1;
  int lowc, highc, fsc, fcyc;
  bit fld0, fs0, fs_seen = 0;

  always @(negedge clk) begin
    if (rst) begin
      cur_v = 0; prev = 1; fs_seen = 0;
    end else begin
      if (frame_start) begin
        if (fs_seen) check(fcyc == FRAME, "R10", "frame length", fcyc, FRAME);
        fs_seen = 1; fcyc = 1;
      end else begin
        fcyc++;
      end
      if (!csync_n && prev) begin
        if (cur_v) begin
          check(lowc == cur.low, tag(cur.idx), $sformatf("entry %0d low", cur.idx), lowc, cur.low);
          check(highc == cur.high, tag(cur.idx), $sformatf("entry %0d high", cur.idx), highc, cur.high);
          check(fld0 == cur.fld, "R9", $sformatf("entry %0d field", cur.idx), fld0, cur.fld);
          check(fs0 == cur.fs && fsc == int'(cur.fs), "R8", $sformatf("entry %0d frame_start count", cur.idx), fsc, cur.fs);
        end
        if (q.size() > 0) begin
          cur = q.pop_front(); cur_v = 1;
        end else begin
          cur_v = 0;
        end
        lowc = 1; highc = 0; fld0 = field; fs0 = frame_start; fsc = frame_start;
      end else begin
        if (!csync_n) lowc++; else highc++;
        fsc += frame_start;
      end
      prev = csync_n;
    end
  end

  initial begin
    int cyc;
    repeat (4) begin
      @(negedge clk); #1;
      check(csync_n == 1'b1, "R1", "csync_n in reset", csync_n, 1);
      check(frame_start == 1'b0, "R1", "frame_start in reset", frame_start, 0);
    end
    // two whole frames plus the start of a third
    push_entries(0, 2 * 622 + 3, cyc);
    @(posedge clk); #2 rst = 1'b0;
    @(negedge clk); #1;
    check(csync_n == 1'b0, "R2", "csync_n after release", csync_n, 0);
    check(frame_start == 1'b1, "R2", "frame_start after release", frame_start, 1);
    repeat (cyc + 2) @(posedge clk);
    #2;
    check(q.size() == 0, "R7", "entries left after wrap", q.size(), 0);
    // reset in the middle of a standard line's high interval
    repeat (30) @(posedge clk);
    #2 rst = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      check(csync_n == 1'b1, "R1", "csync_n in mid-run reset", csync_n, 1);
      check(frame_start == 1'b0, "R1", "frame_start in mid-run reset", frame_start, 0);
    end
    q.delete();
    push_entries(0, 4, cyc);
    @(posedge clk); #2 rst = 1'b0;
    @(negedge clk); #1;
    check(frame_start == 1'b1 && field == 1'b0, "R2", "restart at entry 0", frame_start, 1);
    repeat (cyc + 2) @(posedge clk);
    #2;
    check(q.size() == 0, "R3", "entries left after restart", q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (195000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule